// File: doc/BRIEF.md
# Configuration Image Checksum Verifier

This block watches a stream of 16-bit words that together make up a configuration image, delivered in address order. Each word is qualified by a valid strobe, and a last-word marker tags the end of the image. Every word before the final one is added into a 32-bit running total. The final word is taken as the stored checksum and is compared with the low half of that total.

One clock after the final word is accepted, the block raises a one-cycle done strobe. Alongside it, a pass flag reports whether the image is intact. A total of exactly zero is treated as a blank or absent image, so it fails even when the stored word matches.

The image length is a parameter. When the marker never arrives, the word at that position closes the image on its own. Reading the words out of storage, and using their contents, are left to the surrounding logic.

Top module: `ckv_verifier`

## Requirements
- R1: While reset is high and in the first cycle after it, done_o and pass_o are 0; a reset in the middle of an image discards the partial total.
- R2: The total is the 32-bit sum, wrapping modulo 2^32, of every accepted word before the final word, each zero-extended; the final word is not added.
- R3: pass_o is 1 exactly when the low 16 bits of the total equal the final word and the total is nonzero.
- R4: A 32-bit total of zero gives pass_o = 0 whatever the final word holds. A nonzero total whose low 16 bits are zero (for example 0x0001_0000) passes against a final word of 0x0000.
- R5: A cycle with in_valid = 0 is ignored whatever in_word and in_last carry: it adds nothing, ends no image and raises no done.
- R6: done_o goes high in the cycle after the final word is accepted, and for that cycle only unless another final word is accepted in that cycle; pass_o is only ever 1 together with done_o.
- R7: The final word is the accepted word with in_last = 1, or else the IMG_WORDS-th accepted word of the image, whichever comes first.
- R8: The total returns to zero after each final word, so each image is checked on its own, including images sent back to back.
- R9: An image whose first accepted word carries in_last = 1 has a zero total and therefore fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_word and in_last for this cycle |
| in_word | input | 16 | Image word, address order |
| in_last | input | 1 | Marks the final (checksum) word of the image |
| done_o | output | 1 | One-cycle strobe: an image has just ended |
| pass_o | output | 1 | Verdict, meaningful while done_o is 1 |

## Verification
The verdict registers load on the same rising edge that accepts the final word. They are therefore due exactly one cycle after that word is presented, and they drop again one cycle later. The bench drives every input on the falling edge. It samples done_o and pass_o on the falling edge that follows the accepting rising edge, and checks that done_o is low on the falling edge after that. It also samples done_o half a cycle after every earlier word and after every idle cycle, which confirms that no verdict appears early.

// File: rtl/ckv_pkg.sv
package ckv_pkg;

    localparam int WORD_W = 16;
    localparam int SUM_W  = 32;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SUM_W-1:0]  sum_t;

    typedef struct packed {
        logic done;
        logic pass;
    } verdict_t;

    // Nonzero total whose low half equals the stored checksum word.
    function automatic logic image_ok(sum_t total, word_t stored);
        return (total != '0) && (total[WORD_W-1:0] == stored);
    endfunction

    function automatic sum_t widen(word_t w);
        return {{(SUM_W-WORD_W){1'b0}}, w};
    endfunction

endpackage

// File: rtl/ckv_word_ctr.sv
module ckv_word_ctr #(
    parameter int IMG_WORDS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_last,
    output logic end_now
);
    localparam int CW = (IMG_WORDS > 2) ? $clog2(IMG_WORDS) : 1;
    localparam logic [CW-1:0] LAST_POS = CW'(IMG_WORDS - 1);

    logic [CW-1:0] cnt_q;

    assign end_now = in_valid && (in_last || (cnt_q == LAST_POS));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (in_valid) begin
            cnt_q <= end_now ? '0 : cnt_q + 1'b1;
        end
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_POS);

    // R7
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cnt_q == LAST_POS) |=> cnt_q == '0);

endmodule

// File: rtl/ckv_accum.sv
module ckv_accum
    import ckv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  end_now,
    input  word_t in_word,
    output sum_t  total
);
    sum_t acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (in_valid) begin
            if (end_now) acc_q <= '0;
            else         acc_q <= acc_q + widen(in_word);
        end
    end

    assign total = acc_q;

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> total == $past(total));

    // R8
    end_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && end_now) |=> total == '0);

endmodule

// File: rtl/ckv_judge.sv
module ckv_judge
    import ckv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     end_now,
    input  sum_t     total,
    input  word_t    in_word,
    output verdict_t verdict
);
    verdict_t v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= '0;
        end else begin
            v_q.done <= end_now;
            v_q.pass <= end_now && image_ok(total, in_word);
        end
    end

    assign verdict = v_q;

    // R6
    pass_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        verdict.pass |-> verdict.done);

    // R4
    no_zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
        verdict.pass |-> $past(total) != '0);

    // R3
    match_chk: assert property (@(posedge clk) disable iff (rst)
        verdict.pass |-> $past(total[WORD_W-1:0]) == $past(in_word));

endmodule

// File: rtl/ckv_verifier.sv
module ckv_verifier
    import ckv_pkg::*;
#(
    parameter int IMG_WORDS = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [15:0] in_word,
    input  logic        in_last,
    output logic        done_o,
    output logic        pass_o
);
    logic     end_now;
    sum_t     total;
    verdict_t verdict;

    ckv_word_ctr #(.IMG_WORDS(IMG_WORDS)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_last  (in_last),
        .end_now  (end_now)
    );

    ckv_accum u_acc (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .end_now  (end_now),
        .in_word  (in_word),
        .total    (total)
    );

    ckv_judge u_judge (
        .clk      (clk),
        .rst      (rst),
        .end_now  (end_now),
        .total    (total),
        .in_word  (in_word),
        .verdict  (verdict)
    );

    assign done_o = verdict.done;
    assign pass_o = verdict.pass;

    // R8
    acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> total == '0);

    // R5
    done_src_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(in_valid));

endmodule

// File: tb/ckv_verifier_bench.sv
module ckv_verifier_bench;

    localparam int IMG_WORDS = 32;
    localparam int NV = 7;

    // Table: word count (checksum included), words, expected verdict
    localparam int TN [NV] = '{3, 3, 2, 3, 3, 1, 4};
    localparam logic [15:0] TW [NV][4] = '{
        '{16'h1234, 16'h1111, 16'h2345, 16'h0000},   // R3 match
        '{16'h1234, 16'h1111, 16'h2346, 16'h0000},   // R3 mismatch
        '{16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000},   // single data word
        '{16'hFFFF, 16'h0001, 16'h0000, 16'h0000},   // R4 sum 0x10000
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000},   // R4 zero total
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000},   // R9 last on first
        '{16'h8000, 16'h8000, 16'h0003, 16'h0003}    // R2 carry into bit 16
    };
    localparam bit TP [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        in_last = 1'b0;
    logic        done_o;
    logic        pass_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ckv_verifier #(.IMG_WORDS(IMG_WORDS)) u_ckv_verifier (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_word  (in_word),
        .in_last  (in_last),
        .done_o   (done_o),
        .pass_o   (pass_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [15:0] w, input logic l);
        in_valid = v;
        in_word  = w;
        in_last  = l;
    endtask

    // Called on a falling edge just after the final word's rising edge.
    task automatic expect_verdict(input string req, input logic exp_pass);
        check({req, " done"}, {31'b0, done_o}, 32'd1);
        check({req, " pass"}, {31'b0, pass_o}, {31'b0, exp_pass});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 done in reset", {31'b0, done_o}, 32'd0);
        check("R1 pass in reset", {31'b0, pass_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done after reset", {31'b0, done_o}, 32'd0);

        // Table walk with an idle garbage cycle between words (R5, R8)
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < TN[v]; i++) begin
                drive(1'b1, TW[v][i], i == TN[v] - 1);
                if (i < TN[v] - 1) begin
                    @(negedge clk);
                    check("R5 no early done", {31'b0, done_o}, 32'd0);
                    drive(1'b0, 16'hDEAD, 1'b1);
                    @(negedge clk);
                    check("R5 idle cycle ignored", {31'b0, done_o}, 32'd0);
                end
            end
            @(negedge clk);
            drive(1'b0, 16'h0000, 1'b0);
            expect_verdict($sformatf("R3 vector %0d", v), TP[v]);
            @(negedge clk);
            check("R6 done one cycle", {31'b0, done_o}, 32'd0);
            check("R6 pass drops", {31'b0, pass_o}, 32'd0);
        end

        // R7 length limit closes the image without a marker
        for (int i = 0; i < IMG_WORDS; i++) begin
            drive(1'b1, (i == IMG_WORDS - 1) ? 16'(IMG_WORDS - 1) : 16'h0001, 1'b0);
            @(negedge clk);
            if (i < IMG_WORDS - 1)
                check("R7 no done before limit", {31'b0, done_o}, 32'd0);
        end
        drive(1'b0, 16'h0000, 1'b0);
        expect_verdict("R7 limit word", 1'b1);
        @(negedge clk);
        check("R7 done drops", {31'b0, done_o}, 32'd0);

        // R8 next image starts clean after a limit-closed image
        drive(1'b1, 16'h0042, 1'b0);
        @(negedge clk);
        drive(1'b1, 16'h0042, 1'b1);
        @(negedge clk);
        drive(1'b0, 16'h0000, 1'b0);
        expect_verdict("R8 fresh image", 1'b1);

        // R9 / R6 back-to-back single-word images: done stays high each cycle
        @(negedge clk);
        drive(1'b1, 16'h0000, 1'b1);
        @(negedge clk);
        expect_verdict("R9 first single", 1'b0);
        @(negedge clk);
        drive(1'b0, 16'h0000, 1'b0);
        expect_verdict("R9 second single", 1'b0);
        @(negedge clk);
        check("R6 done falls after pair", {31'b0, done_o}, 32'd0);

        // R1 reset mid-image discards the partial total
        drive(1'b1, 16'h0100, 1'b0);
        @(negedge clk);
        drive(1'b1, 16'h0200, 1'b0);
        @(negedge clk);
        drive(1'b0, 16'h0000, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, 16'h0005, 1'b0);
        @(negedge clk);
        drive(1'b1, 16'h0005, 1'b1);
        @(negedge clk);
        drive(1'b0, 16'h0000, 1'b0);
        expect_verdict("R1 reset clears partial sum", 1'b1);
        @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule